// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits on the write side of a parallel NOR flash interface. It watches every accepted bus write, made of an address and a data word, and recognises the multi-write command sequences a host uses to drive the array. Each recognised operation appears as a one-clock strobe, together with the address and data of the write that completed it. The operations are word program, chip erase, sector erase, erase suspend and erase resume. The embedded program and erase engine consumes these strobes and reports back through a single `busy` input.

The block also selects what host reads should return, through `rd_mode`. The choices are array data, identifier words, CFI query data, and array data while an erase is suspended. In identifier mode the block supplies the identifier word for the read offset itself. A bypass mode shortens program and chip erase to two writes, because the unlock prefix is no longer needed.

The write interface is valid/ready. A write is accepted on a rising clock edge where both `wr_valid` and `wr_ready` are high. `wr_ready` is always high, so the decoder never applies back-pressure and every presented write is taken in a single cycle. The address and data only need to be stable in the cycle where `wr_valid` is high.

Top module: `nor_cmd_decoder`

## Requirements
- R1: After reset, `rd_mode` is 0 (array), every strobe is low and `wr_ready` is high.
- R2: A command opens with two unlock writes: data AA at address 555, then data 55 at address 2AA. Only address bits [11:0] and data bits [7:0] are compared.
- R3: Unlock followed by A0 at 555 makes the next write a program write. One clock after that write is accepted, `prog_stb` pulses, and `op_addr`/`op_data` hold its full address and data.
- R4: Data F0 at any address returns `rd_mode` to 0, or to 3 if an erase is suspended. F0 is not a reset when it is the program data write, or while in bypass mode.
- R5: Unlock followed by 90 at 555 sets `rd_mode` to 1. In that mode, `id_data` for `rd_addr[7:0]` is 0001 at 00, 007E at 01, 000D at 0E and 0000 at 0F. Every other offset, and every other mode, gives 0000.
- R6: Unlock, 80 at 555, then a second unlock pair leads to the final write. Data 10 at 555 pulses `chip_ers_stb`. Data 30 at any address pulses `sect_ers_stb`.
- R7: Data B0 pulses `susp_stb` and sets `rd_mode` to 3, but only while `busy` is high and the last erase started was a sector erase. While suspended and not busy, a single write of 30 from idle pulses `resume_stb`, and `rd_mode` 3 returns to 0.
- R8: From idle, outside bypass mode, data 98 at address 055 sets `rd_mode` to 2. Data 98 at any other address has no effect.
- R9: Unlock followed by 20 at 555 enters bypass mode. In bypass mode, A0 then one write programs, and 80 then 10 starts a chip erase. F0 has no effect. 90 then 00 leaves bypass mode.
- R10: While `busy` is high, every write other than a valid suspend changes nothing and produces no strobe.
- R11: A write that does not match the expected next step abandons the sequence with no strobe, and `rd_mode` keeps its value.
- R12: At most one strobe is high in any cycle, and each strobe lasts one clock.
- R13: While suspended, erase and bypass-entry commands are abandoned at the command write, but program sequences still complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Bus write present |
| wr_ready | output | 1 | Write accepted (always high) |
| wr_addr | input | 22 | Write address |
| wr_data | input | 16 | Write data |
| busy | input | 1 | Embedded program/erase engine running |
| rd_addr | input | 8 | Read offset for identifier data |
| rd_mode | output | 2 | 0 array, 1 identifier, 2 CFI, 3 array while erase suspended |
| id_data | output | 16 | Identifier word for `rd_addr` |
| prog_stb | output | 1 | Program operation strobe |
| chip_ers_stb | output | 1 | Chip erase strobe |
| sect_ers_stb | output | 1 | Sector erase strobe |
| susp_stb | output | 1 | Erase suspend strobe |
| resume_stb | output | 1 | Erase resume strobe |
| op_addr | output | 22 | Address of the write that completed the operation |
| op_data | output | 16 | Data of the write that completed the operation |

## Verification
The hardest state to reach from the ports is the suspended state. Reaching it needs a completed sector erase, then the engine's `busy` raised, then a B0 write inside that busy window. Only once suspended can the resume rule, the reset to mode 3, and the blocking of erase and bypass entry be observed. The stimulus builds that chain on purpose and also sends B0 after a chip erase, to show that the suspend rule depends on the erase kind. A behavioural model in the bench follows every write and is compared with the outputs on every clock.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;
  typedef enum logic [1:0] {
    RM_ARRAY   = 2'd0,
    RM_AUTOSEL = 2'd1,
    RM_CFI     = 2'd2,
    RM_SUSP    = 2'd3
  } rd_mode_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_UNL1, ST_UNL2, ST_PROG,
    ST_ERS1, ST_ERS2, ST_ERS3, ST_BERS, ST_BEXIT
  } seq_st_e;

  typedef struct packed {
    logic       unl_a;   // AA at the command address
    logic       unl_b;   // 55 at the second unlock address
    logic       at_cmd;  // address low bits equal the command address
    logic       at_cfi;  // address low bits equal the query address
    logic [7:0] cmd;     // low data byte
  } wr_dec_t;

  localparam int NSTB   = 5;
  localparam int S_PROG = 0;
  localparam int S_CHIP = 1;
  localparam int S_SECT = 2;
  localparam int S_SUSP = 3;
  localparam int S_RES  = 4;

  localparam logic [7:0] C_RESET   = 8'hF0;
  localparam logic [7:0] C_ASEL    = 8'h90;
  localparam logic [7:0] C_PROG    = 8'hA0;
  localparam logic [7:0] C_ERASE   = 8'h80;
  localparam logic [7:0] C_CHIP    = 8'h10;
  localparam logic [7:0] C_SECTRES = 8'h30;
  localparam logic [7:0] C_SUSP    = 8'hB0;
  localparam logic [7:0] C_CFI     = 8'h98;
  localparam logic [7:0] C_BYPASS  = 8'h20;
  localparam logic [7:0] C_BEXIT   = 8'h00;
endpackage

// File: rtl/nor_cmd_match.sv
module nor_cmd_match
  import nor_cmd_pkg::*;
#(
  parameter int AW     = 22,
  parameter int DW     = 16,
  parameter int CMP_AW = 12
) (
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  output wr_dec_t       dec
);
  localparam logic [CMP_AW-1:0] ADR_CMD = CMP_AW'(12'h555);
  localparam logic [CMP_AW-1:0] ADR_UNB = CMP_AW'(12'h2AA);
  localparam logic [CMP_AW-1:0] ADR_CFI = CMP_AW'(12'h055);

  logic [CMP_AW-1:0] lo;
  logic [7:0]        byte0;

  assign lo    = addr[CMP_AW-1:0];
  assign byte0 = data[7:0];

  always_comb begin
    dec.cmd    = byte0;
    dec.at_cmd = (lo == ADR_CMD);
    dec.at_cfi = (lo == ADR_CFI);
    dec.unl_a  = dec.at_cmd && (byte0 == 8'hAA);
    dec.unl_b  = (lo == ADR_UNB) && (byte0 == 8'h55);
  end

  initial begin
    assert (CMP_AW <= AW && DW >= 8) else $error("nor_cmd_match: widths too small");
  end
endmodule

// File: rtl/nor_id_rom.sv
module nor_id_rom #(
  parameter int          OFS_W  = 8,
  parameter int          DW     = 16,
  parameter logic [15:0] MFR_ID = 16'h0001,
  parameter logic [15:0] DEV_A  = 16'h007E,
  parameter logic [15:0] DEV_B  = 16'h000D,
  parameter logic [15:0] DEV_C  = 16'h0000
) (
  input  logic             en,
  input  logic [OFS_W-1:0] ofs,
  output logic [DW-1:0]    data
);
  always_comb begin
    data = '0;
    if (en) begin
      case (ofs)
        OFS_W'(8'h00): data = DW'(MFR_ID);
        OFS_W'(8'h01): data = DW'(DEV_A);
        OFS_W'(8'h0E): data = DW'(DEV_B);
        OFS_W'(8'h0F): data = DW'(DEV_C);
        default:       data = '0;
      endcase
    end
  end
endmodule

// File: rtl/nor_cmd_fsm.sv
module nor_cmd_fsm
  import nor_cmd_pkg::*;
#(
  parameter int AW = 22,
  parameter int DW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fire,
  input  logic            busy,
  input  wr_dec_t         dec,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   data,
  output rd_mode_e        mode,
  output logic [NSTB-1:0] stb,
  output logic [AW-1:0]   op_addr,
  output logic [DW-1:0]   op_data
);
  seq_st_e         st, nst;
  rd_mode_e        nmode;
  logic            byp, nbyp, susp, nsusp, sect, nsect;
  logic [NSTB-1:0] stb_d;

  always_comb begin
    nst   = st;
    nmode = mode;
    nbyp  = byp;
    nsusp = susp;
    nsect = sect;
    stb_d = '0;
    if (fire) begin
      if (busy) begin
        if (dec.cmd == C_SUSP && sect && !susp) begin
          stb_d[S_SUSP] = 1'b1;
          nsusp = 1'b1;
          nmode = RM_SUSP;
          nst   = ST_IDLE;
        end
      end else if (st == ST_PROG) begin
        stb_d[S_PROG] = 1'b1;
        nst = ST_IDLE;
        if (!susp) nsect = 1'b0;
      end else if (!byp && dec.cmd == C_RESET) begin
        nst   = ST_IDLE;
        nmode = susp ? RM_SUSP : RM_ARRAY;
      end else begin
        nst = ST_IDLE;
        case (st)
          ST_IDLE: begin
            if (byp) begin
              case (dec.cmd)
                C_PROG:  nst = ST_PROG;
                C_ERASE: nst = ST_BERS;
                C_ASEL:  nst = ST_BEXIT;
                default: nst = ST_IDLE;
              endcase
            end else if (dec.unl_a) begin
              nst = ST_UNL1;
            end else if (dec.at_cfi && dec.cmd == C_CFI && mode != RM_CFI) begin
              nmode = RM_CFI;
            end else if (dec.cmd == C_SECTRES && susp) begin
              stb_d[S_RES] = 1'b1;
              nsusp = 1'b0;
              if (mode == RM_SUSP) nmode = RM_ARRAY;
            end
          end
          ST_UNL1: if (dec.unl_b) nst = ST_UNL2;
          ST_UNL2: begin
            if (dec.at_cmd) begin
              case (dec.cmd)
                C_ASEL:   nmode = RM_AUTOSEL;
                C_PROG:   nst = ST_PROG;
                C_ERASE:  if (!susp) nst = ST_ERS1;
                C_BYPASS: if (!susp) nbyp = 1'b1;
                default:  nst = ST_IDLE;
              endcase
            end
          end
          ST_ERS1: if (dec.unl_a) nst = ST_ERS2;
          ST_ERS2: if (dec.unl_b) nst = ST_ERS3;
          ST_ERS3: begin
            if (dec.cmd == C_CHIP && dec.at_cmd) begin
              stb_d[S_CHIP] = 1'b1;
              nsect = 1'b0;
            end else if (dec.cmd == C_SECTRES) begin
              stb_d[S_SECT] = 1'b1;
              nsect = 1'b1;
            end
          end
          ST_BERS: begin
            if (dec.cmd == C_CHIP) begin
              stb_d[S_CHIP] = 1'b1;
              nsect = 1'b0;
            end
          end
          ST_BEXIT: if (dec.cmd == C_BEXIT) nbyp = 1'b0;
          default: nst = ST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      mode    <= RM_ARRAY;
      byp     <= 1'b0;
      susp    <= 1'b0;
      sect    <= 1'b0;
      stb     <= '0;
      op_addr <= '0;
      op_data <= '0;
    end else begin
      st   <= nst;
      mode <= nmode;
      byp  <= nbyp;
      susp <= nsusp;
      sect <= nsect;
      stb  <= stb_d;
      if (|stb_d) begin
        op_addr <= addr;
        op_data <= data;
      end
    end
  end

  // R12: strobes never overlap
  a_r12_one_strobe: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(stb));
  // R10: busy blocks everything except a suspend byte
  a_r10_busy_ignores: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && busy && dec.cmd != C_SUSP) |=> (stb == '0 && $stable(mode)));
  // R7: a suspend is only issued while the engine runs
  a_r7_susp_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
    stb[S_SUSP] |-> $past(busy));
  // R7: a resume follows a suspended state
  a_r7_resume_from_susp: assert property (@(posedge clk) disable iff (!rst_n)
    stb[S_RES] |-> ($past(susp) && !susp));
  // R6: chip erase completes on data 10
  a_r6_chip_byte: assert property (@(posedge clk) disable iff (!rst_n)
    stb[S_CHIP] |-> op_data[7:0] == C_CHIP);
  // R8: query mode is entered only by a 98 write
  a_r8_cfi_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == RM_CFI && $past(mode) != RM_CFI) |-> $past(fire && dec.cmd == C_CFI));
  // R9: reset byte does not leave bypass mode
  a_r9_bypass_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (byp && fire && !busy && st == ST_IDLE && dec.cmd == C_RESET) |=> byp);
endmodule

// File: rtl/nor_cmd_decoder.sv
module nor_cmd_decoder
  import nor_cmd_pkg::*;
#(
  parameter int AW     = 22,
  parameter int DW     = 16,
  parameter int CMP_AW = 12,
  parameter int OFS_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic             busy,
  input  logic [OFS_W-1:0] rd_addr,
  output logic [1:0]       rd_mode,
  output logic [DW-1:0]    id_data,
  output logic             prog_stb,
  output logic             chip_ers_stb,
  output logic             sect_ers_stb,
  output logic             susp_stb,
  output logic             resume_stb,
  output logic [AW-1:0]    op_addr,
  output logic [DW-1:0]    op_data
);
  wr_dec_t         dec;
  rd_mode_e        mode;
  logic [NSTB-1:0] stb;
  logic            fire;

  assign wr_ready = 1'b1;
  assign fire     = wr_valid && wr_ready;

  nor_cmd_match #(.AW(AW), .DW(DW), .CMP_AW(CMP_AW)) match_i (
    .addr(wr_addr), .data(wr_data), .dec(dec)
  );

  nor_cmd_fsm #(.AW(AW), .DW(DW)) fsm_i (
    .clk(clk), .rst_n(rst_n), .fire(fire), .busy(busy), .dec(dec),
    .addr(wr_addr), .data(wr_data), .mode(mode), .stb(stb),
    .op_addr(op_addr), .op_data(op_data)
  );

  nor_id_rom #(.OFS_W(OFS_W), .DW(DW)) rom_i (
    .en(mode == RM_AUTOSEL), .ofs(rd_addr), .data(id_data)
  );

  assign rd_mode      = mode;
  assign prog_stb     = stb[S_PROG];
  assign chip_ers_stb = stb[S_CHIP];
  assign sect_ers_stb = stb[S_SECT];
  assign susp_stb     = stb[S_SUSP];
  assign resume_stb   = stb[S_RES];

  // R1: the write side never stalls
  a_r1_ready: assert property (@(posedge clk) disable iff (!rst_n) wr_valid |-> wr_ready);
endmodule

// File: tb/nor_cmd_decoder_tb_top.sv
`timescale 1ns/1ps
module nor_cmd_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [21:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        busy = 1'b0;
  logic [7:0]  rd_addr = '0;
  logic [1:0]  rd_mode;
  logic [15:0] id_data, op_data;
  logic [21:0] op_addr;
  logic        prog_stb, chip_ers_stb, sect_ers_stb, susp_stb, resume_stb;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  nor_cmd_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .busy(busy), .rd_addr(rd_addr),
    .rd_mode(rd_mode), .id_data(id_data), .prog_stb(prog_stb),
    .chip_ers_stb(chip_ers_stb), .sect_ers_stb(sect_ers_stb),
    .susp_stb(susp_stb), .resume_stb(resume_stb),
    .op_addr(op_addr), .op_data(op_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [4:0] stbs();
    return {resume_stb, susp_stb, sect_ers_stb, chip_ers_stb, prog_stb};
  endfunction

  // ---- behavioural reference model ----
  int         m_step;     // position in the current sequence
  bit         m_byp, m_susp, m_sect;
  int         m_mode;
  logic [4:0] m_stb;
  logic [21:0] m_addr;
  logic [15:0] m_data;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_step = 0; m_byp = 0; m_susp = 0; m_sect = 0; m_mode = 0;
      m_stb = '0; m_addr = '0; m_data = '0;
    end else begin
      logic [7:0]  c;
      logic [11:0] lo;
      int          was;
      c  = wr_data[7:0];
      lo = wr_addr[11:0];
      m_stb = '0;
      if (wr_valid) begin
        if (busy) begin
          if (c == 8'hB0 && m_sect && !m_susp) begin
            m_stb = 5'b01000; m_susp = 1; m_mode = 3; m_step = 0;
          end
        end else if (m_step == 3) begin
          m_stb = 5'b00001; m_step = 0;
          if (!m_susp) m_sect = 0;
        end else if (!m_byp && c == 8'hF0) begin
          m_step = 0; m_mode = m_susp ? 3 : 0;
        end else begin
          was = m_step;
          m_step = 0;
          if (was == 0 && m_byp) begin
            if (c == 8'hA0) m_step = 3;
            else if (c == 8'h80) m_step = 7;
            else if (c == 8'h90) m_step = 8;
          end else if (was == 0) begin
            if (lo == 12'h555 && c == 8'hAA) m_step = 1;
            else if (lo == 12'h055 && c == 8'h98) begin if (m_mode != 2) m_mode = 2; end
            else if (c == 8'h30 && m_susp) begin
              m_stb = 5'b10000; m_susp = 0;
              if (m_mode == 3) m_mode = 0;
            end
          end else if (was == 1 || was == 5) begin
            if (lo == 12'h2AA && c == 8'h55) m_step = was + 1;
          end else if (was == 2 && lo == 12'h555) begin
            if (c == 8'h90) m_mode = 1;
            else if (c == 8'hA0) m_step = 3;
            else if (c == 8'h80 && !m_susp) m_step = 4;
            else if (c == 8'h20 && !m_susp) m_byp = 1;
          end else if (was == 4) begin
            if (lo == 12'h555 && c == 8'hAA) m_step = 5;
          end else if (was == 6) begin
            if (c == 8'h10 && lo == 12'h555) begin m_stb = 5'b00010; m_sect = 0; end
            else if (c == 8'h30) begin m_stb = 5'b00100; m_sect = 1; end
          end else if (was == 7) begin
            if (c == 8'h10) begin m_stb = 5'b00010; m_sect = 0; end
          end else if (was == 8) begin
            if (c == 8'h00) m_byp = 0;
          end
        end
        if (m_stb != 0) begin m_addr = wr_addr; m_data = wr_data; end
      end
    end
  end

  function automatic logic [15:0] id_exp(input int mode, input logic [7:0] o);
    if (mode != 1) return 16'h0000;
    case (o)
      8'h00: return 16'h0001;
      8'h01: return 16'h007E;
      8'h0E: return 16'h000D;
      default: return 16'h0000;
    endcase
  endfunction

  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      chk("R12 model strobes", {27'd0, stbs()}, {27'd0, m_stb});
      chk("R4 model rd_mode", {30'd0, rd_mode}, m_mode);
      chk("R5 model id_data", {16'd0, id_data}, {16'd0, id_exp(m_mode, rd_addr)});
      if (m_stb != 0) begin
        chk("R3 model op_addr", {10'd0, op_addr}, {10'd0, m_addr});
        chk("R3 model op_data", {16'd0, op_data}, {16'd0, m_data});
      end
    end
  end

  // ---- stimulus ----
  task automatic wr(input logic [21:0] a, input logic [15:0] d);
    wr_addr = a; wr_data = d; wr_valid = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic unlock();
    wr(22'h3F555, 16'hFFAA);
    wr(22'h1F2AA, 16'h3355);
  endtask

  task automatic rd_id(input logic [7:0] o, input logic [15:0] e);
    rd_addr = o;
    #0.5;
    chk("R5 id word", {16'd0, id_data}, {16'd0, e});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rd_mode after reset", {30'd0, rd_mode}, 0);
    chk("R1 strobes after reset", {27'd0, stbs()}, 0);
    chk("R1 wr_ready", {31'd0, wr_ready}, 1);

    // R2, R3: program with junk in the don't-care bits
    unlock(); wr(22'h00555, 16'h77A0); wr(22'h12345, 16'hBEEF);
    chk("R3 prog_stb", {31'd0, prog_stb}, 1);
    chk("R3 op_addr", {10'd0, op_addr}, 32'h12345);
    chk("R3 op_data", {16'd0, op_data}, 32'hBEEF);
    @(negedge clk);
    chk("R12 strobe one clock", {31'd0, prog_stb}, 0);

    // R5: identifier mode
    unlock(); wr(22'h00555, 16'h0090);
    chk("R5 rd_mode", {30'd0, rd_mode}, 1);
    rd_id(8'h00, 16'h0001); rd_id(8'h01, 16'h007E);
    rd_id(8'h0E, 16'h000D); rd_id(8'h0F, 16'h0000); rd_id(8'h05, 16'h0000);

    // R11: broken unlock aborts, mode kept
    wr(22'h555, 16'h00AA); wr(22'h2AB, 16'h0055); wr(22'h555, 16'h00A0); wr(22'h100, 16'h1234);
    chk("R11 no program after abort", {31'd0, prog_stb}, 0);
    chk("R11 mode kept", {30'd0, rd_mode}, 1);

    // R4: reset
    wr(22'h0ABCD, 16'h00F0);
    chk("R4 reset to array", {30'd0, rd_mode}, 0);

    // R8: query mode
    wr(22'h00055, 16'h0098);
    chk("R8 cfi entry", {30'd0, rd_mode}, 2);
    wr(22'h0, 16'h00F0);
    wr(22'h00056, 16'h0098);
    chk("R8 wrong address ignored", {30'd0, rd_mode}, 0);

    // R6: chip erase
    unlock(); wr(22'h555, 16'h0080); unlock(); wr(22'h555, 16'h0010);
    chk("R6 chip_ers_stb", {31'd0, chip_ers_stb}, 1);

    // R10: busy blocks writes; B0 after chip erase is not a suspend
    busy = 1'b1;
    unlock(); wr(22'h555, 16'h00A0); wr(22'h200, 16'h5A5A);
    chk("R10 no program while busy", {31'd0, prog_stb}, 0);
    wr(22'h0, 16'h00B0);
    chk("R7 no suspend of chip erase", {31'd0, susp_stb}, 0);
    busy = 1'b0;

    // R6: sector erase
    unlock(); wr(22'h555, 16'h0080); unlock(); wr(22'h2C000, 16'h0030);
    chk("R6 sect_ers_stb", {31'd0, sect_ers_stb}, 1);
    chk("R6 sector address", {10'd0, op_addr}, 32'h2C000);

    // R7: suspend
    busy = 1'b1;
    wr(22'h200000, 16'h00B0);
    chk("R7 susp_stb", {31'd0, susp_stb}, 1);
    chk("R7 suspended mode", {30'd0, rd_mode}, 3);
    busy = 1'b0;

    // R13: erase blocked, program allowed while suspended
    unlock(); wr(22'h555, 16'h0080); unlock(); wr(22'h555, 16'h0010);
    chk("R13 no chip erase in suspend", {31'd0, chip_ers_stb}, 0);
    unlock(); wr(22'h555, 16'h00A0); wr(22'h300, 16'hC3C3);
    chk("R13 program in suspend", {31'd0, prog_stb}, 1);

    // R4: reset returns to suspended mode
    unlock(); wr(22'h555, 16'h0090);
    chk("R5 id mode in suspend", {30'd0, rd_mode}, 1);
    wr(22'h0, 16'h00F0);
    chk("R4 reset in suspend", {30'd0, rd_mode}, 3);

    // R7: resume
    wr(22'h200000, 16'h0030);
    chk("R7 resume_stb", {31'd0, resume_stb}, 1);
    chk("R7 mode after resume", {30'd0, rd_mode}, 0);
    wr(22'h200000, 16'h0030);
    chk("R7 no resume when not suspended", {31'd0, resume_stb}, 0);

    // R9: bypass mode
    unlock(); wr(22'h555, 16'h0020);
    wr(22'h0, 16'h00A0); wr(22'h77, 16'h5555);
    chk("R9 bypass program", {31'd0, prog_stb}, 1);
    wr(22'h0, 16'h0080); wr(22'h0, 16'h0010);
    chk("R9 bypass chip erase", {31'd0, chip_ers_stb}, 1);
    wr(22'h0, 16'h00F0); wr(22'h0, 16'h00A0); wr(22'h1, 16'h0001);
    chk("R9 F0 ignored in bypass", {31'd0, prog_stb}, 1);
    wr(22'h0, 16'h0090); wr(22'h0, 16'h0000);
    wr(22'h0, 16'h00A0); wr(22'h2, 16'h0002);
    chk("R9 bypass exited", {31'd0, prog_stb}, 0);
    chk("R9 mode after exit", {30'd0, rd_mode}, 0);

    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule